// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the execute-stage arithmetic and logic unit of a 32-bit RISC core. Each cycle it takes a first operand from the register file, a second operand that has already passed through the barrel shifter, the carry produced by that shifter, a 4-bit operation code, a flag-set bit, a 4-bit condition field and the current N, Z, C and V flags. It returns the operation result, a write enable for the destination register and the next value of the four flags.

The condition field is checked against the incoming flags. When the condition holds, the result is marked for writing and the flags may be updated. When it fails, the write is suppressed and the flags pass through unchanged. The four compare and test operations only affect flags and never ask for a write. All outputs are captured in one execute-stage register, so they appear one clock after the inputs.

Top module: `dp_alu`

## Requirements
- R1: Logical operations give these results, with the operation codes 0000 AND (rn & op2), 0001 EOR (rn ^ op2), 1100 ORR (rn | op2), 1101 MOV (op2, rn ignored), 1110 BIC (rn & ~op2) and 1111 MVN (~op2, rn ignored).
- R2: Arithmetic operations give these results, with C being the incoming carry flag: 0010 SUB rn−op2, 0011 RSB op2−rn, 0100 ADD rn+op2, 0101 ADC rn+op2+C, 0110 SBC rn−op2+C−1, 0111 RSC op2−rn+C−1, all modulo 2^32.
- R3: The codes 1000 TST (rn & op2), 1001 TEQ (rn ^ op2), 1010 CMP (rn−op2) and 1011 CMN (rn+op2) never assert the write enable, but update flags like the other operations.
- R4: When the flag-set bit is 0, the flag output equals the flag input.
- R5: When flags are updated, N equals result bit 31 and Z is 1 exactly when the result is zero. The flag bus is ordered {N,Z,C,V} from bit 3 down to bit 0.
- R6: For arithmetic operations, including CMP and CMN, C is the carry out of the adder (1 when a subtraction has no borrow), and V is set on signed overflow.
- R7: For logical operations, including TST and TEQ, C is taken from the shifter carry input and V keeps its input value.
- R8: The condition codes are 0000 EQ Z; 0001 NE !Z; 0010 CS C; 0011 CC !C; 0100 MI N; 0101 PL !N; 0110 VS V; 0111 VC !V; 1000 HI C&!Z; 1001 LS !C|Z; 1010 GE N==V; 1011 LT N!=V; 1100 GT !Z&(N==V); 1101 LE Z|(N!=V); 1110 AL always. A passing condition on a non-test operation asserts the write enable.
- R9: The code 1111 never passes. A failing condition gives a write enable of 0 and flags equal to the input flags, whatever the flag-set bit is.
- R10: Outputs are registered. Values reflect the inputs present at the previous rising clock edge. While rst_n is low at an edge, result, write enable and flags all clear to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rn_i | input | 32 | First operand |
| op2_i | input | 32 | Second operand from the shifter |
| shift_c_i | input | 1 | Carry out of the shifter |
| opcode_i | input | 4 | Operation code |
| set_flags_i | input | 1 | Allow flag update |
| cond_i | input | 4 | Condition field |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| result_o | output | 32 | Operation result (registered) |
| wr_en_o | output | 1 | Destination write enable (registered) |
| flags_o | output | 4 | Next flags {N,Z,C,V} (registered) |

## Verification
Operand pairs are chosen so that each arithmetic code produces a different flag pattern. Signed overflow at the 0x7FFFFFFF boundary separates V from C. Unsigned wrap to zero separates C from V and sets Z. Equal and unequal subtractions separate borrow from no-borrow, and carry-in cases show that ADC, SBC and RSC really use the incoming C. Logical operations are given a set V flag and a shifter carry, so the bench can see that V is held and that C comes from the shifter rather than the adder. All sixteen condition codes are tried against all sixteen flag combinations, which separates each code from its complement.

// File: rtl/dp_alu_pkg.sv
// Package: shared encodings for the data-processing ALU.
// Assumes the flag bus order {N,Z,C,V}, most significant first.
package dp_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'b0000, OP_EOR = 4'b0001, OP_SUB = 4'b0010, OP_RSB = 4'b0011,
        OP_ADD = 4'b0100, OP_ADC = 4'b0101, OP_SBC = 4'b0110, OP_RSC = 4'b0111,
        OP_TST = 4'b1000, OP_TEQ = 4'b1001, OP_CMP = 4'b1010, OP_CMN = 4'b1011,
        OP_ORR = 4'b1100, OP_MOV = 4'b1101, OP_BIC = 4'b1110, OP_MVN = 4'b1111
    } opcode_e;

    typedef enum logic [3:0] {
        CC_EQ = 4'b0000, CC_NE = 4'b0001, CC_CS = 4'b0010, CC_CC = 4'b0011,
        CC_MI = 4'b0100, CC_PL = 4'b0101, CC_VS = 4'b0110, CC_VC = 4'b0111,
        CC_HI = 4'b1000, CC_LS = 4'b1001, CC_GE = 4'b1010, CC_LT = 4'b1011,
        CC_GT = 4'b1100, CC_LE = 4'b1101, CC_AL = 4'b1110, CC_NV = 4'b1111
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    // True for operations whose result goes through the adder.
    function automatic logic op_is_arith(opcode_e op);
        return (op inside {OP_SUB, OP_RSB, OP_ADD, OP_ADC, OP_SBC, OP_RSC,
                           OP_CMP, OP_CMN});
    endfunction

    // True for operations that only produce flags.
    function automatic logic op_is_test(opcode_e op);
        return (op inside {OP_TST, OP_TEQ, OP_CMP, OP_CMN});
    endfunction

endpackage

// File: rtl/dp_cond_check.sv
// Condition evaluator: decides from the condition field and the current
// flags whether the operation takes effect. Purely combinational.
// Assumes the code 1111 means "never".
module dp_cond_check
    import dp_alu_pkg::*;
(
    input  cond_e  cond_i,
    input  flags_t flags_i,
    output logic   pass_o
);

    logic n_eq_v;

    // Signed-compare helper shared by GE/LT/GT/LE.
    always_comb n_eq_v = (flags_i.n == flags_i.v);

    // Decode the condition field against the flags.
    always_comb begin
        unique case (cond_i)
            CC_EQ: pass_o = flags_i.z;
            CC_NE: pass_o = !flags_i.z;
            CC_CS: pass_o = flags_i.c;
            CC_CC: pass_o = !flags_i.c;
            CC_MI: pass_o = flags_i.n;
            CC_PL: pass_o = !flags_i.n;
            CC_VS: pass_o = flags_i.v;
            CC_VC: pass_o = !flags_i.v;
            CC_HI: pass_o = flags_i.c && !flags_i.z;
            CC_LS: pass_o = !flags_i.c || flags_i.z;
            CC_GE: pass_o = n_eq_v;
            CC_LT: pass_o = !n_eq_v;
            CC_GT: pass_o = !flags_i.z && n_eq_v;
            CC_LE: pass_o = flags_i.z || !n_eq_v;
            CC_AL: pass_o = 1'b1;
            default: pass_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/dp_logic_unit.sv
// Bitwise unit: computes the logical operations, including TST/TEQ.
// Arithmetic codes give zero here; the top selects the adder for them.
module dp_logic_unit
    import dp_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  opcode_e          op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] res_o
);

    // Select the bitwise function named by the operation code.
    always_comb begin
        unique case (op_i)
            OP_AND, OP_TST: res_o = a_i & b_i;
            OP_EOR, OP_TEQ: res_o = a_i ^ b_i;
            OP_ORR:         res_o = a_i | b_i;
            OP_MOV:         res_o = b_i;
            OP_BIC:         res_o = a_i & ~b_i;
            OP_MVN:         res_o = ~b_i;
            default:        res_o = '0;
        endcase
    end

endmodule

// File: rtl/dp_adder.sv
// Adder path: maps every arithmetic code onto one a + b + cin sum.
// Subtraction uses the inverted subtrahend with a carry in, so the carry
// out is the inverted borrow. Non-arithmetic codes produce don't-care sums.
module dp_adder
    import dp_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  opcode_e          op_i,
    input  logic [WIDTH-1:0] rn_i,
    input  logic [WIDTH-1:0] op2_i,
    input  logic             c_in_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             c_out_o,
    output logic             v_out_o
);

    localparam int EXT = WIDTH + 1;

    logic [WIDTH-1:0] opa, opb;
    logic             cin;
    logic [EXT-1:0]   total;

    // Pick the adder operands and the carry in for each operation.
    always_comb begin
        opa = rn_i;
        opb = op2_i;
        cin = 1'b0;
        unique case (op_i)
            OP_SUB, OP_CMP: begin opb = ~op2_i; cin = 1'b1;   end
            OP_RSB:         begin opa = op2_i; opb = ~rn_i; cin = 1'b1; end
            OP_ADC:         begin cin = c_in_i;                end
            OP_SBC:         begin opb = ~op2_i; cin = c_in_i; end
            OP_RSC:         begin opa = op2_i; opb = ~rn_i; cin = c_in_i; end
            default:        begin cin = 1'b0;                  end
        endcase
    end

    // One carry-propagate sum with an extra bit for the carry out.
    always_comb total = {1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, cin};

    // Split the sum and derive signed overflow from the operand signs.
    always_comb begin
        sum_o   = total[WIDTH-1:0];
        c_out_o = total[WIDTH];
        v_out_o = (opa[WIDTH-1] == opb[WIDTH-1]) && (sum_o[WIDTH-1] != opa[WIDTH-1]);
    end

endmodule

// File: rtl/dp_alu.sv
// Data-processing ALU top: combines the logic unit, the adder and the
// condition evaluator, builds the next flags and registers all outputs
// in the execute-stage register. Synchronous active-low reset.
// Assumes op2_i and shift_c_i come from the shifter in the same cycle.
module dp_alu
    import dp_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] rn_i,
    input  logic [WIDTH-1:0] op2_i,
    input  logic             shift_c_i,
    input  logic [3:0]       opcode_i,
    input  logic             set_flags_i,
    input  logic [3:0]       cond_i,
    input  logic [3:0]       flags_i,
    output logic [WIDTH-1:0] result_o,
    output logic             wr_en_o,
    output logic [3:0]       flags_o
);

    opcode_e          op;
    flags_t           cur_f, nxt_f;
    logic             pass, arith, test_only;
    logic [WIDTH-1:0] logic_res, add_res, res_d;
    logic             add_c, add_v;

    // Cast the raw ports onto the shared types.
    always_comb begin
        op    = opcode_e'(opcode_i);
        cur_f = flags_t'(flags_i);
    end

    dp_cond_check u_cond (
        .cond_i  (cond_e'(cond_i)),
        .flags_i (cur_f),
        .pass_o  (pass)
    );

    dp_logic_unit #(.WIDTH(WIDTH)) u_logic (
        .op_i  (op),
        .a_i   (rn_i),
        .b_i   (op2_i),
        .res_o (logic_res)
    );

    dp_adder #(.WIDTH(WIDTH)) u_add (
        .op_i    (op),
        .rn_i    (rn_i),
        .op2_i   (op2_i),
        .c_in_i  (cur_f.c),
        .sum_o   (add_res),
        .c_out_o (add_c),
        .v_out_o (add_v)
    );

    // Classify the operation and pick the result source.
    always_comb begin
        arith     = op_is_arith(op);
        test_only = op_is_test(op);
        res_d     = arith ? add_res : logic_res;
    end

    // Build the next flags; hold them on a failed condition or clear S.
    always_comb begin
        nxt_f = cur_f;
        if (pass && set_flags_i) begin
            nxt_f.n = res_d[WIDTH-1];
            nxt_f.z = (res_d == '0);
            nxt_f.c = arith ? add_c : shift_c_i;
            nxt_f.v = arith ? add_v : cur_f.v;
        end
    end

    // Execute-stage register for result, write enable and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            wr_en_o  <= 1'b0;
            flags_o  <= '0;
        end else begin
            result_o <= res_d;
            wr_en_o  <= pass && !test_only;
            flags_o  <= nxt_f;
        end
    end

endmodule

// File: rtl/dp_alu_chk.sv
// Checker for dp_alu: relates registered outputs to the inputs one
// clock earlier. Attached to every dp_alu instance by the bind below.
module dp_alu_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] rn_i,
    input logic [WIDTH-1:0] op2_i,
    input logic             shift_c_i,
    input logic [3:0]       opcode_i,
    input logic             set_flags_i,
    input logic [3:0]       cond_i,
    input logic [3:0]       flags_i,
    input logic [WIDTH-1:0] result_o,
    input logic             wr_en_o,
    input logic [3:0]       flags_o
);

    logic is_logical;

    // Logical class: codes 0000, 0001, 1000, 1001 and 11xx.
    always_comb is_logical = (opcode_i[2:1] == 2'b00) || (opcode_i[3:2] == 2'b11);

    // R1: MOV passes the second operand through.
    a_r1_mov_passes_op2: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode_i == 4'b1101) |=> (result_o == $past(op2_i)));

    // R3: compare/test codes never request a write.
    a_r3_test_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode_i[3:2] == 2'b10) |=> !wr_en_o);

    // R4: flags pass through when the flag-set bit is clear.
    a_r4_flags_held: assert property (@(posedge clk) disable iff (!rst_n)
        !set_flags_i |=> (flags_o == $past(flags_i)));

    // R5: N and Z follow the result when flags are updated unconditionally.
    a_r5_nz_from_result: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i == 4'b1110 && set_flags_i) |=>
        (flags_o[3] == result_o[WIDTH-1]) && (flags_o[2] == (result_o == '0)));

    // R7: logical ops take C from the shifter and keep V.
    a_r7_logic_c_v: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i == 4'b1110 && set_flags_i && is_logical) |=>
        (flags_o[1] == $past(shift_c_i)) && (flags_o[0] == $past(flags_i[0])));

    // R9: the never code blocks the write and the flag update.
    a_r9_never_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i == 4'b1111) |=> (!wr_en_o && flags_o == $past(flags_i)));

endmodule

bind dp_alu dp_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rn_i        (rn_i),
    .op2_i       (op2_i),
    .shift_c_i   (shift_c_i),
    .opcode_i    (opcode_i),
    .set_flags_i (set_flags_i),
    .cond_i      (cond_i),
    .flags_i     (flags_i),
    .result_o    (result_o),
    .wr_en_o     (wr_en_o),
    .flags_o     (flags_o)
);

// File: tb/dp_alu_tb.sv
// Directed bench for dp_alu: one task per scenario, each checking itself.
module dp_alu_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] rn, op2;
    logic        shc;
    logic [3:0]  opc;
    logic        sbit;
    logic [3:0]  cond;
    logic [3:0]  fin;
    logic [31:0] result;
    logic        wr_en;
    logic [3:0]  flags;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dp_alu u_dut (
        .clk(clk), .rst_n(rst_n), .rn_i(rn), .op2_i(op2), .shift_c_i(shc),
        .opcode_i(opc), .set_flags_i(sbit), .cond_i(cond), .flags_i(fin),
        .result_o(result), .wr_en_o(wr_en), .flags_o(flags)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one operation just after an edge, sample just after the next.
    task automatic run(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic s, input logic sc, input logic [3:0] c, input logic [3:0] f);
        opc = o; rn = a; op2 = b; sbit = s; shc = sc; cond = c; fin = f;
        @(posedge clk);
        #1;
    endtask

    // Full check of one unconditional operation.
    task automatic op_case(input string tag, input logic [3:0] o, input logic [31:0] a,
                           input logic [31:0] b, input logic sc, input logic [3:0] f,
                           input logic [31:0] exp_res, input logic exp_wr, input logic [3:0] exp_f);
        run(o, a, b, 1'b1, sc, 4'b1110, f);
        chk({tag, " result"}, result, exp_res);
        chk({tag, " wr_en"}, {31'd0, wr_en}, {31'd0, exp_wr});
        chk({tag, " flags"}, {28'd0, flags}, {28'd0, exp_f});
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        run(4'b0100, 32'h1234, 32'h1, 1'b1, 1'b1, 4'b1110, 4'hF);
        chk("R10 reset result", result, 32'd0);
        chk("R10 reset wr_en", {31'd0, wr_en}, 32'd0);
        chk("R10 reset flags", {28'd0, flags}, 32'd0);
        rst_n = 1'b1;
        run(4'b1101, 32'h0, 32'h0, 1'b0, 1'b0, 4'b1110, 4'h0);
    endtask

    task automatic t_logical;
        op_case("R1 R7 AND", 4'b0000, 32'hF0F0_FF00, 32'h0FF0_F0F0, 1'b1, 4'b0001,
                32'h00F0_F000, 1'b1, 4'b0011);
        op_case("R1 R5 EOR", 4'b0001, 32'hFFFF_0000, 32'h0F0F_0F0F, 1'b0, 4'b0011,
                32'hF0F0_0F0F, 1'b1, 4'b1001);
        op_case("R1 ORR", 4'b1100, 32'h1200_0000, 32'h0000_0034, 1'b0, 4'b0000,
                32'h1200_0034, 1'b1, 4'b0000);
        op_case("R1 BIC", 4'b1110, 32'h1234_5678, 32'h0000_FFFF, 1'b1, 4'b0000,
                32'h1234_0000, 1'b1, 4'b0010);
        op_case("R1 R5 MOV", 4'b1101, 32'hDEAD_BEEF, 32'h0, 1'b0, 4'b0000,
                32'h0, 1'b1, 4'b0100);
        op_case("R1 MVN", 4'b1111, 32'hDEAD_BEEF, 32'h0, 1'b0, 4'b0001,
                32'hFFFF_FFFF, 1'b1, 4'b1001);
    endtask

    task automatic t_arith;
        op_case("R2 R6 ADD overflow", 4'b0100, 32'h7FFF_FFFF, 32'h1, 1'b1, 4'b0000,
                32'h8000_0000, 1'b1, 4'b1001);
        op_case("R2 R6 ADD wrap", 4'b0100, 32'hFFFF_FFFF, 32'h1, 1'b0, 4'b0001,
                32'h0, 1'b1, 4'b0110);
        op_case("R2 R6 SUB noborrow", 4'b0010, 32'd5, 32'd3, 1'b0, 4'b0000,
                32'd2, 1'b1, 4'b0010);
        op_case("R2 R6 SUB borrow", 4'b0010, 32'd3, 32'd5, 1'b1, 4'b0010,
                32'hFFFF_FFFE, 1'b1, 4'b1000);
        op_case("R2 R6 SUB overflow", 4'b0010, 32'h8000_0000, 32'd1, 1'b0, 4'b0000,
                32'h7FFF_FFFF, 1'b1, 4'b0011);
        op_case("R2 RSB", 4'b0011, 32'd3, 32'd10, 1'b0, 4'b0000,
                32'd7, 1'b1, 4'b0010);
        op_case("R2 ADC", 4'b0101, 32'd1, 32'd2, 1'b1, 4'b0010,
                32'd4, 1'b1, 4'b0000);
        op_case("R2 SBC", 4'b0110, 32'd10, 32'd3, 1'b0, 4'b0000,
                32'd6, 1'b1, 4'b0010);
        op_case("R2 RSC", 4'b0111, 32'd3, 32'd10, 1'b0, 4'b0010,
                32'd7, 1'b1, 4'b0010);
    endtask

    task automatic t_tests;
        run(4'b1010, 32'd5, 32'd5, 1'b1, 1'b0, 4'b1110, 4'b0000);
        chk("R3 CMP wr_en", {31'd0, wr_en}, 32'd0);
        chk("R3 R6 CMP flags", {28'd0, flags}, 32'b0110);
        run(4'b1000, 32'h0F, 32'hF0, 1'b1, 1'b1, 4'b1110, 4'b0001);
        chk("R3 TST wr_en", {31'd0, wr_en}, 32'd0);
        chk("R3 R7 TST flags", {28'd0, flags}, 32'b0111);
        run(4'b1011, 32'hFFFF_FFFF, 32'd1, 1'b1, 1'b0, 4'b1110, 4'b1000);
        chk("R3 R6 CMN flags", {28'd0, flags}, 32'b0110);
        run(4'b1001, 32'h8000_0000, 32'h0, 1'b1, 1'b0, 4'b1110, 4'b0010);
        chk("R3 TEQ wr_en", {31'd0, wr_en}, 32'd0);
        chk("R3 TEQ flags", {28'd0, flags}, 32'b1000);
    endtask

    task automatic t_sbit;
        run(4'b0100, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b1, 4'b1110, 4'b1010);
        chk("R4 S clear result", result, 32'd0);
        chk("R4 S clear wr_en", {31'd0, wr_en}, 32'd1);
        chk("R4 S clear flags", {28'd0, flags}, 32'b1010);
    endtask

    function automatic logic exp_pass(input logic [3:0] c, input logic [3:0] f);
        logic n, z, cy, v;
        {n, z, cy, v} = f;
        case (c)
            4'h0: return z;          4'h1: return !z;
            4'h2: return cy;         4'h3: return !cy;
            4'h4: return n;          4'h5: return !n;
            4'h6: return v;          4'h7: return !v;
            4'h8: return cy && !z;   4'h9: return !cy || z;
            4'hA: return n == v;     4'hB: return n != v;
            4'hC: return !z && (n == v);
            4'hD: return z || (n != v);
            4'hE: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic t_cond_table;
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 16; f++) begin
                run(4'b1101, 32'h0, 32'h5, 1'b0, 1'b0, 4'(c), 4'(f));
                chk($sformatf("R8 R9 cond %0d flags %0d wr_en", c, f),
                    {31'd0, wr_en}, {31'd0, exp_pass(4'(c), 4'(f))});
            end
        end
    endtask

    task automatic t_cond_fail;
        run(4'b0100, 32'hFFFF_FFFF, 32'd1, 1'b1, 1'b1, 4'b0000, 4'b0000);
        chk("R9 EQ fail wr_en", {31'd0, wr_en}, 32'd0);
        chk("R9 EQ fail flags", {28'd0, flags}, 32'b0000);
        run(4'b0010, 32'd1, 32'd1, 1'b1, 1'b0, 4'b1111, 4'b1001);
        chk("R9 never wr_en", {31'd0, wr_en}, 32'd0);
        chk("R9 never flags", {28'd0, flags}, 32'b1001);
        run(4'b0100, 32'd1, 32'd1, 1'b1, 1'b0, 4'b0000, 4'b0100);
        chk("R8 EQ pass wr_en", {31'd0, wr_en}, 32'd1);
        chk("R8 EQ pass flags", {28'd0, flags}, 32'b0000);
    endtask

    task automatic t_latency;
        run(4'b1101, 32'h0, 32'hAAAA_5555, 1'b0, 1'b0, 4'b1110, 4'b0000);
        opc = 4'b1101; op2 = 32'h1357_9BDF;
        #3;
        chk("R10 before edge", result, 32'hAAAA_5555);
        @(posedge clk);
        #1;
        chk("R10 after edge", result, 32'h1357_9BDF);
    endtask

    initial begin
        #100us;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        rn = '0; op2 = '0; shc = 1'b0; opc = '0; sbit = 1'b0; cond = 4'hE; fin = '0;
        @(posedge clk);
        #1;
        t_reset();
        t_logical();
        t_arith();
        t_tests();
        t_sbit();
        t_cond_table();
        t_cond_fail();
        t_latency();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule